// File: doc/BRIEF.md
# Integer ALU with 32-bit word mode

This block is the purely combinational integer datapath of a 64-bit RISC-V style core. Two operand buses, a four-bit operation code and a word-mode flag go in; one result bus and an illegal-operation flag come out in the same cycle. It covers the add, subtract, compare, bitwise logic and shift operations.

The decoder in front of the block does all immediate handling, including sign extension and upper-immediate assembly, and puts the finished value on operand B. The block therefore treats register and immediate forms the same way. Word mode narrows add, subtract and the three shifts to the low 32 bits and widens the 32-bit answer by copying its bit 31 into every higher bit.

Top module: `int_alu`

## Requirements
- R1: Op code 0 (add) gives (A + B) modulo 2^XLEN. The carry out is dropped.
- R2: Op code 1 (subtract) gives (A - B) modulo 2^XLEN. The borrow is dropped.
- R3: Op code 2 (signed less-than) gives 1 when A is below B as two's complement numbers and 0 otherwise. Every result bit above bit 0 is zero.
- R4: Op code 3 (unsigned less-than) gives 1 when A is below B as unsigned numbers and 0 otherwise. With B equal to 1 the result is therefore 1 exactly when A is zero.
- R5: Op codes 4, 5 and 6 give the bitwise AND, OR and XOR of A and B.
- R6: In full-width mode, op codes 7, 8 and 9 are the left-logical, right-logical and right-arithmetic shifts. Each shifts A by B[5:0], which is B[log2(XLEN)-1:0] in general. Logical shifts fill vacated bits with zeros. The arithmetic shift fills them with A[XLEN-1].
- R7: With word_i set, op codes 0, 1, 7, 8 and 9 act only on A[31:0] and B[31:0], and shifts use B[4:0]. The 32-bit answer is sign-extended from its bit 31 to the full width, so the upper operand bits have no effect.
- R8: The word-mode arithmetic right shift takes its fill bit from A[31], not from A[63].
- R9: Op codes 10 to 15, and op codes 2 to 6 with word_i set, are illegal. An illegal operation gives an all-zero result with illegal_o at 1. Every legal operation drives illegal_o to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | XLEN | Operand A |
| b_i | input | XLEN | Operand B (register value or decoded immediate) |
| op_i | input | 4 | Operation code |
| word_i | input | 1 | Selects 32-bit word mode |
| result_o | output | XLEN | Operation result |
| illegal_o | output | 1 | Marks an unsupported operation and word-mode pairing |

## Verification
Every result and the illegal flag depend only on the current inputs, so each one is due in the same cycle as its stimulus, with no register in between. The bench applies each operand and op-code vector, lets it settle for a fraction of a nanosecond, and samples the outputs before it applies the next vector; the clock only drives the watchdog. A narrow 8-bit build with a 4-bit word is swept exhaustively over both operands, and the default 64-bit build is checked with directed corner vectors for carries, sign fill and shift-amount masking.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int XLEN = 64,
  parameter int WLEN = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [3:0]      op_i,
  input  logic            word_i,
  output logic [XLEN-1:0] result_o,
  output logic            illegal_o
);

  localparam int SHW  = $clog2(XLEN);
  localparam int WSHW = $clog2(WLEN);

  localparam logic [3:0] OP_ADD  = 4'd0;
  localparam logic [3:0] OP_SUB  = 4'd1;
  localparam logic [3:0] OP_SLT  = 4'd2;
  localparam logic [3:0] OP_SLTU = 4'd3;
  localparam logic [3:0] OP_AND  = 4'd4;
  localparam logic [3:0] OP_OR   = 4'd5;
  localparam logic [3:0] OP_XOR  = 4'd6;
  localparam logic [3:0] OP_SLL  = 4'd7;
  localparam logic [3:0] OP_SRL  = 4'd8;
  localparam logic [3:0] OP_SRA  = 4'd9;

  logic [SHW-1:0]  shamt;
  logic [WSHW-1:0] wshamt;
  logic [WLEN-1:0] aw, bw;
  logic [WLEN-1:0] w_add, w_sub, w_sll, w_srl, w_sra;
  logic            lt_s, lt_u;

  assign shamt  = b_i[SHW-1:0];
  assign wshamt = b_i[WSHW-1:0];
  assign aw     = a_i[WLEN-1:0];
  assign bw     = b_i[WLEN-1:0];
  assign w_add  = aw + bw;
  assign w_sub  = aw - bw;
  assign w_sll  = aw << wshamt;
  assign w_srl  = aw >> wshamt;
  assign w_sra  = $signed(aw) >>> wshamt;
  assign lt_s   = $signed(a_i) < $signed(b_i);
  assign lt_u   = a_i < b_i;

  function automatic logic [XLEN-1:0] sext(input logic [WLEN-1:0] v);
    return {{(XLEN-WLEN){v[WLEN-1]}}, v};
  endfunction

  always_comb begin
    result_o  = '0;
    illegal_o = 1'b0;
    if (word_i) begin
      case (op_i)
        OP_ADD:  result_o = sext(w_add);
        OP_SUB:  result_o = sext(w_sub);
        OP_SLL:  result_o = sext(w_sll);
        OP_SRL:  result_o = sext(w_srl);
        OP_SRA:  result_o = sext(w_sra);
        default: illegal_o = 1'b1;
      endcase
    end else begin
      case (op_i)
        OP_ADD:  result_o = a_i + b_i;
        OP_SUB:  result_o = a_i - b_i;
        OP_SLT:  result_o = {{(XLEN-1){1'b0}}, lt_s};
        OP_SLTU: result_o = {{(XLEN-1){1'b0}}, lt_u};
        OP_AND:  result_o = a_i & b_i;
        OP_OR:   result_o = a_i | b_i;
        OP_XOR:  result_o = a_i ^ b_i;
        OP_SLL:  result_o = a_i << shamt;
        OP_SRL:  result_o = a_i >> shamt;
        OP_SRA:  result_o = $signed(a_i) >>> shamt;
        default: illegal_o = 1'b1;
      endcase
    end
  end

  always_comb begin
    if (!$isunknown({a_i, b_i, op_i, word_i})) begin
      if (illegal_o)
        AST_ILLEGAL_ZERO: assert (result_o == '0); // R9
      if (!illegal_o && !word_i && (op_i == OP_SLT || op_i == OP_SLTU))
        AST_SLT_ONEBIT: assert (result_o[XLEN-1:1] == '0); // R3
      if (!illegal_o && word_i)
        AST_WORD_SEXT: assert (result_o[XLEN-1:WLEN-1] == '0 || &result_o[XLEN-1:WLEN-1]); // R7
      if (!illegal_o && !word_i && op_i == OP_ADD)
        AST_ADD_INVERSE: assert (result_o - b_i == a_i); // R1
      if (!illegal_o && !word_i && op_i == OP_SUB)
        AST_SUB_INVERSE: assert (result_o + b_i == a_i); // R2
    end
  end

endmodule

// File: tb/int_alu_tb.sv
`timescale 1ns/10ps
module int_alu_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  int n_run  = 0;
  int n_fail = 0;
  int cycles = 0;

  logic [63:0] a, b;
  logic [3:0]  op;
  logic        w;
  logic [63:0] res;
  logic        ill;

  int_alu u_dut (.a_i(a), .b_i(b), .op_i(op), .word_i(w), .result_o(res), .illegal_o(ill));

  logic [7:0] sa, sb;
  logic [3:0] sop;
  logic       sw;
  logic [7:0] sres;
  logic       sill;

  int_alu #(.XLEN(8), .WLEN(4)) u_dut_small (
    .a_i(sa), .b_i(sb), .op_i(sop), .word_i(sw), .result_o(sres), .illegal_o(sill));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic [3:0] o, logic wm, logic [63:0] x, logic [63:0] y,
                       string req, logic [63:0] exp, logic exp_ill);
    op = o; w = wm; a = x; b = y;
    #1;
    chk(req, res, exp);
    chk(req, {63'd0, ill}, {63'd0, exp_ill});
  endtask

  function automatic string tag(int o, bit wm);
    if (o >= 10 || (wm && o >= 2 && o <= 6)) return "R9";
    if (wm) return (o == 9) ? "R8" : "R7";
    case (o)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4, 5, 6: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic void ref8(int o, bit wm, int x, int y, output int r, output bit il);
    int sx, sy, sh, xw, yw, v;
    sx = (x >= 128) ? x - 256 : x;
    sy = (y >= 128) ? y - 256 : y;
    il = 1'b0;
    r  = 0;
    if (wm) begin
      xw = x % 16; yw = y % 16; sh = y % 4;
      case (o)
        0: v = (xw + yw) % 16;
        1: v = (xw - yw + 16) % 16;
        7: v = (xw * (1 << sh)) % 16;
        8: v = xw / (1 << sh);
        9: v = (((xw >= 8) ? xw - 16 : xw) >>> sh) & 15;
        default: begin il = 1'b1; v = 0; end
      endcase
      r = il ? 0 : ((v >= 8) ? v + 240 : v);
    end else begin
      sh = y % 8;
      case (o)
        0: r = (x + y) % 256;
        1: r = (x - y + 256) % 256;
        2: r = (sx < sy) ? 1 : 0;
        3: r = (x < y) ? 1 : 0;
        4: r = x & y;
        5: r = x | y;
        6: r = x ^ y;
        7: r = (x * (1 << sh)) % 256;
        8: r = x / (1 << sh);
        9: r = (sx >>> sh) & 255;
        default: il = 1'b1;
      endcase
    end
  endfunction

  task automatic sweep(int o, bit wm, int step);
    int r;
    bit il;
    for (int x = 0; x < 256; x += step) begin
      for (int y = 0; y < 256; y += step) begin
        sop = o[3:0]; sw = wm; sa = x[7:0]; sb = y[7:0];
        #0.1;
        ref8(o, wm, x, y, r, il);
        n_run++;
        if (sres !== r[7:0] || sill !== il) begin
          n_fail++;
          $display("FAIL %s: op %0d w %0d a %0d b %0d actual %h/%b expected %h/%b",
                   tag(o, wm), o, wm, x, y, sres, sill, r[7:0], il);
        end
      end
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    a = '0; b = '0; op = '0; w = 1'b0;
    sa = '0; sb = '0; sop = '0; sw = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // reset state: zero inputs, add
    apply(4'd0, 1'b0, 64'd0, 64'd0, "R1", 64'd0, 1'b0);
    apply(4'd0, 1'b0, '1, 64'd1, "R1", 64'd0, 1'b0);
    apply(4'd1, 1'b0, 64'd0, 64'd1, "R2", '1, 1'b0);
    apply(4'd1, 1'b0, 64'd10, 64'd3, "R2", 64'd7, 1'b0);
    apply(4'd2, 1'b0, '1, 64'd1, "R3", 64'd1, 1'b0);
    apply(4'd2, 1'b0, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, "R3", 64'd1, 1'b0);
    apply(4'd3, 1'b0, '1, 64'd1, "R4", 64'd0, 1'b0);
    apply(4'd3, 1'b0, 64'd0, 64'd1, "R4", 64'd1, 1'b0);
    apply(4'd3, 1'b0, 64'd5, 64'd1, "R4", 64'd0, 1'b0);
    apply(4'd4, 1'b0, 64'hF0F0_0000_FFFF_1234, 64'hFF00_FFFF_0F0F_00FF, "R5", 64'hF000_0000_0F0F_0034, 1'b0);
    apply(4'd5, 1'b0, 64'hF0F0_0000_FFFF_1234, 64'hFF00_FFFF_0F0F_00FF, "R5", 64'hFFF0_FFFF_FFFF_12FF, 1'b0);
    apply(4'd6, 1'b0, 64'h1234_5678_9ABC_DEF0, '1, "R5", 64'hEDCB_A987_6543_210F, 1'b0);
    apply(4'd7, 1'b0, 64'd1, 64'd63, "R6", 64'h8000_0000_0000_0000, 1'b0);
    apply(4'd7, 1'b0, 64'd1, 64'h41, "R6", 64'd2, 1'b0);
    apply(4'd8, 1'b0, 64'h8000_0000_0000_0000, 64'd63, "R6", 64'd1, 1'b0);
    apply(4'd9, 1'b0, 64'h8000_0000_0000_0000, 64'd63, "R6", '1, 1'b0);
    apply(4'd9, 1'b0, 64'h4000_0000_0000_0000, 64'd32, "R6", 64'h0000_0000_4000_0000, 1'b0);
    apply(4'd0, 1'b1, 64'h7FFF_FFFF, 64'd1, "R7", 64'hFFFF_FFFF_8000_0000, 1'b0);
    apply(4'd0, 1'b1, 64'hDEAD_BEEF_0000_0001, 64'h1234_5678_0000_0002, "R7", 64'd3, 1'b0);
    apply(4'd1, 1'b1, 64'hFFFF_FFFF_0000_0000, 64'd1, "R7", '1, 1'b0);
    apply(4'd7, 1'b1, 64'd1, 64'd31, "R7", 64'hFFFF_FFFF_8000_0000, 1'b0);
    apply(4'd7, 1'b1, 64'd1, 64'h21, "R7", 64'd2, 1'b0);
    apply(4'd8, 1'b1, 64'h8000_0000, 64'd0, "R7", 64'hFFFF_FFFF_8000_0000, 1'b0);
    apply(4'd8, 1'b1, 64'hFFFF_FFFF_8000_0000, 64'd1, "R7", 64'h4000_0000, 1'b0);
    apply(4'd9, 1'b1, 64'h8000_0000, 64'd4, "R8", 64'hFFFF_FFFF_F800_0000, 1'b0);
    apply(4'd9, 1'b1, 64'h8000_0000_4000_0000, 64'd1, "R8", 64'h2000_0000, 1'b0);
    apply(4'd15, 1'b0, '1, '1, "R9", 64'd0, 1'b1);
    apply(4'd10, 1'b0, 64'd7, 64'd9, "R9", 64'd0, 1'b1);
    apply(4'd4, 1'b1, '1, '1, "R9", 64'd0, 1'b1);
    apply(4'd2, 1'b1, 64'd0, 64'd1, "R9", 64'd0, 1'b1);

    for (int o = 0; o < 10; o++) sweep(o, 1'b0, 1);
    sweep(0, 1'b1, 1);
    sweep(1, 1'b1, 1);
    sweep(7, 1'b1, 1);
    sweep(8, 1'b1, 1);
    sweep(9, 1'b1, 1);
    for (int o = 2; o < 7; o++) sweep(o, 1'b1, 5);
    for (int o = 10; o < 16; o++) begin
      sweep(o, 1'b0, 5);
      sweep(o, 1'b1, 5);
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule